// File: doc/BRIEF.md
# Serial Seven-Segment Display Driver

This block refreshes a row of seven-segment digits using just two output wires: a serial data line and a shift clock. Each digit on the board has its own 8-bit shift register. The registers are daisy-chained: the last stage of one register drives the data input of the next. On a start request, the driver captures the segment bytes for all digits. It then clocks them out as one serial burst and pulses `done` once the final bit has been shifted.

Segment bytes arrive as "lit" patterns, where a 1 means the segment should glow. Bit 7 down to bit 0 stand for segments h (the decimal point), g, f, e, d, c, b, a. A build parameter chooses the display polarity. For common-anode displays every bit is inverted before it is sent, because there a 0 lights a segment. For common-cathode displays the bits go out unchanged. The shift-clock period is a parameter: each half period lasts `HALF_DIV` system clocks. A bit counter loaded with the total bit count runs down to zero to end the burst.

Top module: `serialSegDriver`

## Requirements
- R1: After reset, `serClk`, `serData`, `busy` and `done` are all low.
- R2: While no transfer is running, `serClk` stays low.
- R3: A start request accepted while idle produces exactly DIGITS*8 rising edges on `serClk`. Digit 0 (`segCodes[7:0]`) goes first and digit DIGITS-1 last. Within each byte, bit 0 (segment a) goes first and bit 7 (segment h) last.
- R4: With `COMMON_ANODE`=1 each transmitted bit is the inverse of the lit bit, so the letter A (lit 0x77) goes out as 10001000. With `COMMON_ANODE`=0 each bit goes out unchanged.
- R5: `serClk` is high for `HALF_DIV` cycles and low for `HALF_DIV` cycles between rises. `serData` changes only in the cycle where `serClk` falls, so it is set up `HALF_DIV` cycles before each rise and held while `serClk` is high.
- R6: The first `serClk` rise is visible `HALF_DIV` cycles after the edge that accepts start. `done` is high for exactly one cycle, 64*`HALF_DIV` cycles (for 4 digits) after that edge, which is the cycle after the final fall.
- R7: A start request while `busy` is high is ignored. The running burst continues with its original codes and its original timing.
- R8: After a burst into a chain of DIGITS 8-bit registers, the register farthest from the driver holds digit 0. Each register holds its byte with the first-sent bit in its last stage.
- R9: `busy` is high from the edge that accepts start through the final `serClk` fall, and low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a refresh burst (taken when idle) |
| segCodes | input | DIGITS*8 | Lit segment bytes; digit 0 in bits 7:0 |
| serData | output | 1 | Serial segment data |
| serClk | output | 1 | Shift clock for the digit registers |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The accepting edge is the time origin for each burst. The first shift-clock rise is due `HALF_DIV` cycles after it, later rises follow every 2*`HALF_DIV` cycles, and `done` is due after 64*`HALF_DIV` cycles. The bench stores the cycle number of the accepting edge and compares each rise and the `done` pulse against those offsets. It samples every output on the falling system clock edge, so each registered change is observed in the cycle where it first becomes visible. The expected bit stream is queued when the burst is requested and is consumed one bit per observed rise. A model of the digit register chain is compared byte by byte at `done`.

// File: rtl/serialSegPkg.sv
package serialSegPkg;
  typedef struct packed {
    logic load;   // capture codes, reload bit counter
    logic tick;   // shift clock rises: count one bit
    logic shift;  // shift clock falls: present next bit
  } segStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} segPhase_t;
endpackage

// File: rtl/serialSegCtrl.sv
module serialSegCtrl
  import serialSegPkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       countZero,
  output segStrobe_t strobe,
  output logic       serClk,
  output logic       busy,
  output logic       done
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  segPhase_t phase;
  logic [DIV_W-1:0] divCnt;
  logic halfDone;

  assign halfDone = (divCnt == DIV_LAST);
  assign busy = (phase != PH_IDLE);

  always_comb begin
    strobe = '0;
    unique case (phase)
      PH_IDLE: strobe.load  = start;
      PH_LOW:  strobe.tick  = halfDone;
      PH_HIGH: strobe.shift = halfDone && !countZero;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      divCnt <= '0;
      serClk <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          divCnt <= '0;
          if (start) phase <= PH_LOW;
        end
        PH_LOW: begin
          if (halfDone) begin
            phase  <= PH_HIGH;
            serClk <= 1'b1;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (halfDone) begin
            serClk <= 1'b0;
            divCnt <= '0;
            if (countZero) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              phase <= PH_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: done lasts one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: shift clock parked low when idle
  assert_clk_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serClk);
  // R5: a rise is only requested from the low half
  assert_tick_from_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> $rose(serClk));
endmodule

// File: rtl/serialSegPath.sv
module serialSegPath
  import serialSegPkg::*;
#(
  parameter int DIGITS       = 4,
  parameter int SEG_W        = 8,
  parameter bit COMMON_ANODE = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  segStrobe_t                strobe,
  input  logic [DIGITS*SEG_W-1:0]   segCodes,
  output logic                      serData,
  output logic                      countZero
);
  localparam int TOTAL = DIGITS * SEG_W;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [TOTAL-1:0] driveCodes;
  logic [TOTAL-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;

  generate
    if (COMMON_ANODE) begin : g_anode
      assign driveCodes = ~segCodes;   // 0 lights a segment
    end else begin : g_cathode
      assign driveCodes = segCodes;    // 1 lights a segment
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (strobe.load) begin
        shiftReg <= driveCodes;
        bitCnt   <= CNT_W'(TOTAL);
      end else begin
        if (strobe.shift) shiftReg <= shiftReg >> 1;
        if (strobe.tick)  bitCnt   <= bitCnt - 1'b1;
      end
    end
  end

  assign serData   = shiftReg[0];
  assign countZero = (bitCnt == '0);

  // R6: counter only climbs on a reload
  assert_count_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt > $past(bitCnt)) |-> $past(strobe.load));
  // R3: never more rises than bits
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |-> !countZero);
endmodule

// File: rtl/serialSegDriver.sv
module serialSegDriver
  import serialSegPkg::*;
#(
  parameter int DIGITS       = 4,
  parameter int SEG_W        = 8,
  parameter int HALF_DIV     = 4,
  parameter bit COMMON_ANODE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [DIGITS*SEG_W-1:0] segCodes,
  output logic                    serData,
  output logic                    serClk,
  output logic                    busy,
  output logic                    done
);
  segStrobe_t strobe;
  logic countZero;

  serialSegCtrl #(.HALF_DIV(HALF_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .countZero(countZero),
    .strobe(strobe), .serClk(serClk), .busy(busy), .done(done)
  );

  serialSegPath #(.DIGITS(DIGITS), .SEG_W(SEG_W), .COMMON_ANODE(COMMON_ANODE)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .segCodes(segCodes),
    .serData(serData), .countZero(countZero)
  );

  // R5: data held through the high half
  assert_data_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData));
  // R5: data already settled at the rise
  assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> $stable(serData));
  // R9: done comes after busy ends
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/test_serialSegDriver.sv
module test_serialSegDriver;
  localparam int HALF = 4;
  localparam int NBITS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] segCodes = '0;
  logic serData, serClk, busy, done;
  logic serDataCc, serClkCc, busyCc, doneCc;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int startCyc = 0;
  int lastRiseCyc = 0;
  int risesSeen = 0;
  int highCnt = 0;
  bit expQ[$];
  logic [31:0] chain = '0;
  logic prevClk = 1'b0, prevData = 1'b0, prevDone = 1'b0;

  always #5 clk = ~clk;

  serialSegDriver #(.HALF_DIV(HALF), .COMMON_ANODE(1'b1)) i_serialSegDriver (
    .clk(clk), .rstN(rstN), .start(start), .segCodes(segCodes),
    .serData(serData), .serClk(serClk), .busy(busy), .done(done));

  serialSegDriver #(.HALF_DIV(HALF), .COMMON_ANODE(1'b0)) i_serialSegDriverCc (
    .clk(clk), .rstN(rstN), .start(start), .segCodes(segCodes),
    .serData(serDataCc), .serClk(serClkCc), .busy(busyCc), .done(doneCc));

  always @(posedge clk) cyc <= cyc + 1;

  // digit register chain: new bits enter the nearest register
  always @(posedge serClk) chain <= {chain[30:0], serData};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  // monitor: consumes the expected stream as the design produces it
  always @(negedge clk) begin
    if (rstN) begin
      if (serClk && !prevClk) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 extra rise", 32'(risesSeen), 32'(NBITS));
        end else begin
          bit e;
          e = expQ.pop_front();
          check(serData == ~e ? 1'b0 : 1'b1, "R3 bit order", 32'(serData), 32'(e));
          check(serDataCc == !e, "R4 cathode bit", 32'(serDataCc), 32'(!e));
          if (risesSeen == 0)
            check(cyc == startCyc + HALF, "R6 first rise", 32'(cyc - startCyc), 32'(HALF));
          else if (cyc - lastRiseCyc != 2 * HALF)
            check(1'b0, "R5 rise spacing", 32'(cyc - lastRiseCyc), 32'(2 * HALF));
        end
        lastRiseCyc = cyc;
        risesSeen++;
      end
      if (serClk) highCnt++;
      if (!serClk && prevClk) begin
        if (highCnt != HALF) check(1'b0, "R5 high width", 32'(highCnt), 32'(HALF));
        highCnt = 0;
      end
      if (serClk && prevClk && serData != prevData)
        check(1'b0, "R5 data moved while high", 32'(serData), 32'(prevData));
      if (!busy && serClk) check(1'b0, "R2 clock idle low", 32'(serClk), 32'd0);
      if (done) begin
        check(cyc == startCyc + 2 * HALF * NBITS, "R6 done timing", 32'(cyc - startCyc), 32'(2 * HALF * NBITS));
        check(expQ.size() == 0 && risesSeen == NBITS, "R3 rise count", 32'(risesSeen), 32'(NBITS));
        check(!busy, "R9 busy low at done", 32'(busy), 32'd0);
      end
      if (done && prevDone) check(1'b0, "R6 done width", 32'd2, 32'd1);
    end
    prevClk = serClk;
    prevData = serData;
    prevDone = done;
  end

  // driver: queues the expected stream and launches a burst
  task automatic runBurst(input logic [7:0] d0, d1, d2, d3, input bit poke);
    logic [31:0] lit;
    lit = {d3, d2, d1, d0};
    for (int d = 0; d < 4; d++)
      for (int j = 0; j < 8; j++)
        expQ.push_back(~lit[8*d + j]);
    risesSeen = 0;
    @(negedge clk);
    segCodes = lit;
    start = 1'b1;
    @(negedge clk);
    startCyc = cyc;
    start = 1'b0;
    check(busy, "R9 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      repeat (50) @(negedge clk);
      segCodes = ~lit;  // R7: this request must be ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    for (int d = 0; d < 4; d++)
      check(chain[31-8*d -: 8] == rev8(~lit[8*d +: 8]), "R8 chain digit",
            32'(chain[31-8*d -: 8]), 32'(rev8(~lit[8*d +: 8])));
    @(negedge clk);
    check(!busy && !serClk && !done, "R2 idle after burst",
          {29'd0, busy, serClk, done}, 32'd0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!serClk && !serData && !busy && !done, "R1 reset state",
          {28'd0, serClk, serData, busy, done}, 32'd0);
    // R4: letter A in digit 0 goes out as 10001000 (anode)
    runBurst(8'h77, 8'h06, 8'h5B, 8'h80, 1'b0);
    check(rev8(chain[31:24]) == 8'b1000_1000, "R4 letter A anode", 32'(rev8(chain[31:24])), 32'h88);
    runBurst(8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0);
    // R7 start while busy ignored
    runBurst(8'hA5, 8'h3C, 8'h01, 8'h80, 1'b1);
    runBurst(8'h6D, 8'h7D, 8'h07, 8'h7F, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule